// File: doc/BRIEF.md
# DDR Read Burst Data Sequencer

This block turns a single read-start pulse into one read data burst for a double-data-rate bus. The two clock edges are modelled as two beat slots per clock: an even lane and an odd lane. A full burst moves eight 64-bit beats in four clocks. On every busy clock the block gives the index of the two beats it needs. A combinational word source answers with the two words. The block registers them onto the output lanes, together with per-lane valid flags and a strobe enable.

A chop flag taken with the start pulse shortens the data, not the slot. Only the first four beats are delivered. The burst still holds the bus for four clocks, and in its last two clocks the strobe enable and the valid flags are held low. A new start that lands on the last busy clock chains a second burst with no idle gap. A start at any other busy clock is refused and reported on a one-cycle error pulse.

Top module: `ddr_rd_burst_seq`

## Requirements
- R1: After reset, busy, rdErr, validEven, validOdd and dqsEn are low, and doutEven and doutOdd are zero.
- R2: A start accepted at a clock edge drives busy high for exactly 4 clocks, whether or not the burst is chopped.
- R3: During busy clock c (c = 0..3), srcIdxEven equals 2c and srcIdxOdd equals 2c+1. While idle, both indexes are 0 and 1.
- R4: In the clock after busy clock c of an unmasked beat pair, doutEven and doutOdd carry the source words at indexes 2c and 2c+1, and validEven and validOdd are high.
- R5: An unchopped burst (rdChop low with the start) delivers 8 beats, with both valid flags high on 4 consecutive clocks starting two clocks after the start pulse.
- R6: A chopped burst (rdChop high with the start) delivers only beats 0 to 3. Both valid flags and dqsEn are low for the outputs of busy clocks 2 and 3.
- R7: While the valid flags are low (masked beats or idle), doutEven and doutOdd keep their previous values.
- R8: dqsEn is high in exactly the clocks in which validEven and validOdd are high.
- R9: A start that is high during the last busy clock begins the next burst at once: busy does not drop, and the valid flags run on without a gap.
- R10: A start during busy clocks 0 to 2 is ignored. rdErr goes high for the one clock that follows, and the running burst continues unchanged.
- R11: rdChop is sampled only with an accepted start. Changes to it during a burst do not affect that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdStart | input | 1 | Read-start pulse |
| rdChop | input | 1 | Chop flag, sampled with an accepted start |
| srcDataEven | input | 64 | Source word at srcIdxEven |
| srcDataOdd | input | 64 | Source word at srcIdxOdd |
| srcIdxEven | output | 3 | Even beat index requested this clock |
| srcIdxOdd | output | 3 | Odd beat index requested this clock |
| doutEven | output | 64 | First-edge beat data |
| doutOdd | output | 64 | Second-edge beat data |
| validEven | output | 1 | First-edge beat valid |
| validOdd | output | 1 | Second-edge beat valid |
| dqsEn | output | 1 | Strobe enable |
| busy | output | 1 | Burst slot occupied |
| rdErr | output | 1 | One-clock pulse for a refused start |

## Verification
Busy rises one clock after the start edge, and the beat indexes are valid in that same clock. Each beat pair reaches the output lanes one register later, so the data of busy clock c appears two clocks after the start plus c. A refused start shows on rdErr in the clock that follows it. The bench drives inputs on falling edges and samples on the next falling edge, so each clock's checks see these offsets directly. It sweeps chains of one to three bursts over every chop pattern, every refused-start position, and late chop-flag changes.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;
  // Strobes from the control to the datapath for one beat pair.
  typedef struct packed {
    logic load;  // a burst clock is in progress
    logic mask;  // this beat pair lies in the chopped half
  } seqStrobe_t;
endpackage

// File: rtl/rdseq_ctrl.sv
module rdseq_ctrl
  import rdseq_pkg::*;
#(
  parameter int BEATS = 8,
  localparam int CLKS = BEATS / 2,
  localparam int CW = (CLKS > 1) ? $clog2(CLKS) : 1,
  localparam int HALF = CLKS / 2,
  localparam int IDX_W = CW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdStart,
  input  logic             rdChop,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] beatBase,
  output logic             busy,
  output logic             rdErr
);
  logic          active;
  logic          chopQ;
  logic          errQ;
  logic [CW-1:0] clkCnt;
  logic          lastClk;
  logic          accept;

  assign lastClk = active && (clkCnt == CW'(CLKS - 1));
  assign accept  = rdStart && (!active || lastClk);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      chopQ  <= 1'b0;
      clkCnt <= '0;
      errQ   <= 1'b0;
    end else begin
      errQ <= rdStart && active && !lastClk;
      if (accept) begin
        active <= 1'b1;
        chopQ  <= rdChop;
        clkCnt <= '0;
      end else if (lastClk) begin
        active <= 1'b0;
        clkCnt <= '0;
      end else if (active) begin
        clkCnt <= clkCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobe.load = active;
    strobe.mask = active && chopQ && (clkCnt >= CW'(HALF));
  end

  assign beatBase = {clkCnt, 1'b0};
  assign busy     = active;
  assign rdErr    = errQ;
endmodule

// File: rtl/rdseq_datapath.sv
module rdseq_datapath
  import rdseq_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int LANES = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqStrobe_t                   strobe,
  input  logic [LANES-1:0][DATA_W-1:0] srcLane,
  output logic [LANES-1:0][DATA_W-1:0] laneOut,
  output logic [LANES-1:0]             laneVld,
  output logic                         dqsEn
);
  logic drive;
  assign drive = strobe.load && !strobe.mask;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneOut[g] <= '0;
        laneVld[g] <= 1'b0;
      end else begin
        laneVld[g] <= drive;
        if (drive) laneOut[g] <= srcLane[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dqsEn <= 1'b0;
    else       dqsEn <= drive;
  end
endmodule

// File: rtl/ddr_rd_burst_seq.sv
module ddr_rd_burst_seq
  import rdseq_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int BEATS = 8,
  localparam int IDX_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStart,
  input  logic              rdChop,
  input  logic [DATA_W-1:0] srcDataEven,
  input  logic [DATA_W-1:0] srcDataOdd,
  output logic [IDX_W-1:0]  srcIdxEven,
  output logic [IDX_W-1:0]  srcIdxOdd,
  output logic [DATA_W-1:0] doutEven,
  output logic [DATA_W-1:0] doutOdd,
  output logic              validEven,
  output logic              validOdd,
  output logic              dqsEn,
  output logic              busy,
  output logic              rdErr
);
  seqStrobe_t               strobe;
  logic [IDX_W-1:0]         beatBase;
  logic [1:0][DATA_W-1:0]   srcLane;
  logic [1:0][DATA_W-1:0]   laneOut;
  logic [1:0]               laneVld;

  rdseq_ctrl #(.BEATS(BEATS)) uCtrl (
    .clk(clk), .rstN(rstN), .rdStart(rdStart), .rdChop(rdChop),
    .strobe(strobe), .beatBase(beatBase), .busy(busy), .rdErr(rdErr)
  );

  assign srcIdxEven = beatBase;
  assign srcIdxOdd  = beatBase | IDX_W'(1);
  assign srcLane[0] = srcDataEven;
  assign srcLane[1] = srcDataOdd;

  rdseq_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .srcLane(srcLane),
    .laneOut(laneOut), .laneVld(laneVld), .dqsEn(dqsEn)
  );

  assign doutEven  = laneOut[0];
  assign doutOdd   = laneOut[1];
  assign validEven = laneVld[0];
  assign validOdd  = laneVld[1];
endmodule

// File: rtl/rdseq_checker.sv
module rdseq_checker #(
  parameter int DATA_W = 64,
  parameter int IDX_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdStart,
  input logic              rdChop,
  input logic [IDX_W-1:0]  srcIdxEven,
  input logic [DATA_W-1:0] doutEven,
  input logic [DATA_W-1:0] doutOdd,
  input logic              validEven,
  input logic              validOdd,
  input logic              dqsEn,
  input logic              busy,
  input logic              rdErr
);
  assert_busy_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 busy ##1 busy);

  assert_idle_index_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> srcIdxEven == '0);

  assert_valid_follows_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    validEven |-> $past(busy));

  assert_full_burst_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStart && !rdChop && !busy) |-> ##2 validEven ##1 validEven ##1 validEven ##1 validEven);

  assert_chop_mask_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStart && rdChop && !busy) |-> ##4 (!validEven && !dqsEn) ##1 (!validEven && !dqsEn));

  assert_hold_even_R7: assert property (@(posedge clk) disable iff (!rstN)
    !validEven |-> $stable(doutEven));

  assert_hold_odd_R7: assert property (@(posedge clk) disable iff (!rstN)
    !validOdd |-> $stable(doutOdd));

  assert_strobe_match_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dqsEn == validEven) && (validOdd == validEven));

  assert_err_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> ($past(busy) && $past(rdStart)));
endmodule

bind ddr_rd_burst_seq rdseq_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .rdStart(rdStart), .rdChop(rdChop),
  .srcIdxEven(srcIdxEven), .doutEven(doutEven), .doutOdd(doutOdd),
  .validEven(validEven), .validOdd(validOdd), .dqsEn(dqsEn),
  .busy(busy), .rdErr(rdErr)
);

// File: tb/sim_ddr_rd_burst_seq.sv
module sim_ddr_rd_burst_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdStart = 1'b0;
  logic        rdChop = 1'b0;
  logic [63:0] srcDataEven, srcDataOdd, doutEven, doutOdd;
  logic [2:0]  srcIdxEven, srcIdxOdd;
  logic        validEven, validOdd, dqsEn, busy, rdErr;

  int checks = 0;
  int failures = 0;
  logic [63:0] heldE = '0;
  logic [63:0] heldO = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [63:0] word(input int i);
    logic [31:0] v;
    v = i;
    return {32'hC0DE_0000 + v, 32'h5A5A_0000 ^ (v * 32'h0101_0101)};
  endfunction

  assign srcDataEven = word(int'(srcIdxEven));
  assign srcDataOdd  = word(int'(srcIdxOdd));

  ddr_rd_burst_seq u0 (
    .clk(clk), .rstN(rstN), .rdStart(rdStart), .rdChop(rdChop),
    .srcDataEven(srcDataEven), .srcDataOdd(srcDataOdd),
    .srcIdxEven(srcIdxEven), .srcIdxOdd(srcIdxOdd),
    .doutEven(doutEven), .doutOdd(doutOdd),
    .validEven(validEven), .validOdd(validOdd), .dqsEn(dqsEn),
    .busy(busy), .rdErr(rdErr)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Output clock after busy clock c of a burst with chop flag ch.
  task automatic expectPair(input int c, input bit ch);
    bit masked;
    masked = ch && (c >= 2);
    if (!masked) begin
      heldE = word(2 * c);
      heldO = word(2 * c + 1);
    end
    chk(validEven == !masked && validOdd == !masked, masked ? "R6 valid masked" : "R5 valid",
        {validEven, validOdd}, {!masked, !masked});
    chk(dqsEn == !masked, "R8 dqsEn", dqsEn, !masked);
    chk(doutEven == heldE && doutOdd == heldO, masked ? "R7 hold" : "R4 data",
        {doutEven, doutOdd}, {heldE, heldO});
  endtask

  // Chain of n seamless bursts; optional refused start at clock errAt of burst 0.
  task automatic runSeq(input int n, input bit [3:0] chops, input int errAt, input bit lateChop);
    int pc;
    bit pch;
    pc = -1;
    pch = 1'b0;
    @(negedge clk);
    rdStart = 1'b1;
    rdChop = chops[0];
    for (int b = 0; b < n; b++) begin
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        rdStart = 1'b0;
        rdChop = lateChop ? !chops[b] : 1'b0;
        chk(busy == 1'b1, (b > 0 && c == 0) ? "R9 no gap busy" : "R2 busy", busy, 1'b1);
        chk(srcIdxEven == 3'(2 * c) && srcIdxOdd == 3'(2 * c + 1), "R3 index",
            {srcIdxEven, srcIdxOdd}, {3'(2 * c), 3'(2 * c + 1)});
        chk(rdErr == (b == 0 && errAt >= 0 && c == errAt + 1), "R10 err pulse",
            rdErr, (b == 0 && errAt >= 0 && c == errAt + 1));
        if (pc >= 0) expectPair(pc, pch);
        pc = c;
        pch = chops[b];
        if (c == 3 && b < n - 1) begin
          rdStart = 1'b1;
          rdChop = chops[b + 1];
        end else if (b == 0 && c == errAt) begin
          rdStart = 1'b1;
        end
      end
    end
    @(negedge clk);
    rdStart = 1'b0;
    rdChop = 1'b0;
    chk(busy == 1'b0, "R2 busy ends", busy, 1'b0);
    chk(rdErr == 1'b0, "R10 no err", rdErr, 1'b0);
    expectPair(3, pch);
    @(negedge clk);
    chk(!validEven && !validOdd && !dqsEn, "R7 idle valid low", {validEven, validOdd, dqsEn}, 3'b000);
    chk(doutEven == heldE && doutOdd == heldO, "R7 idle hold", {doutEven, doutOdd}, {heldE, heldO});
    chk(srcIdxEven == 3'd0 && srcIdxOdd == 3'd1, "R3 idle index", {srcIdxEven, srcIdxOdd}, {3'd0, 3'd1});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !rdErr && !validEven && !validOdd && !dqsEn, "R1 reset flags",
        {busy, rdErr, validEven, validOdd, dqsEn}, 5'b0);
    chk(doutEven == '0 && doutOdd == '0, "R1 reset data", {doutEven, doutOdd}, 128'b0);
    rstN = 1'b1;
    @(negedge clk);
    // Single and chained bursts over every chop pattern.
    for (int n = 1; n <= 3; n++) begin
      for (int p = 0; p < (1 << n); p++) begin
        runSeq(n, 4'(p), -1, 1'b0);
      end
    end
    // Refused starts at each non-boundary busy clock (R10).
    for (int e = 0; e < 3; e++) begin
      for (int ch = 0; ch < 2; ch++) begin
        runSeq(1, 4'(ch), e, 1'b0);
      end
    end
    // Chop flag toggled during the burst has no effect (R11).
    runSeq(1, 4'b0000, -1, 1'b1);
    runSeq(1, 4'b0001, -1, 1'b1);
    runSeq(2, 4'b0010, -1, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule